// File: doc/BRIEF.md
# Comparator Output Conditioner

This block takes the one-bit result of an analog comparator and turns it into clean, clock-aligned logic. The raw result is first brought into the bus clock domain through a two-flop synchronizer and can optionally be inverted. After that, a mode select chooses how the result reaches the output:

- **Continuous:** it follows the result on every cycle.
- **Sampled:** it is captured on sample ticks.
- **Sampled and filtered:** it changes only after several agreeing samples.
- **Windowed:** it passes while a window input is high and holds the last value while the window is low.
- **Windowed and filtered:** the windowed value is fed through the sample filter.

Sample ticks come from a programmable divider on the bus clock. In the sampled modes, a select bit can swap the divider for the rising edges of an external strobe. In the windowed modes, that same strobe input, synchronized, is the window.

Edges on the final output set sticky rising and falling flags, which are cleared by a write-1 pulse. Each flag has an interrupt enable. A routing bit sends the enabled events to a DMA request instead of to the interrupt lines. A pin select chooses whether the pin output carries the conditioned result or the merely synchronized and inverted one.

Top module: `cmpout_conditioner`

## Requirements
- R1: In mode 0 (continuous), `cout` equals the synchronized result, with a delay of two clock edges after `comp_raw` changes.
- R2: With `invert`=1, the synchronized result is inverted before all mode logic and before the unfiltered path.
- R3: While `enable`=0, `cout` and `pin_out` are 0, and the held value and the filter state are cleared.
- R4: In mode 1 (sampled), `cout` only changes on a sample tick. With the internal divider, a tick occurs once every `prescale`+1 cycles.
- R5: In mode 2 (sampled and filtered), `cout` takes a new state only after `filt_cnt`=N consecutive ticks have seen that state. N=0 means no filtering, so every tick is taken directly.
- R6: In mode 3 (windowed), `cout` follows the result while the synchronized `ext_strobe` is 1. While it is 0, `cout` holds the last value that passed.
- R7: In mode 4 (windowed and filtered), the windowed value is passed through the N-sample filter of R5, which runs on internal divider ticks.
- R8: With `ext_sel`=1 in modes 1 and 2, a sample tick is the rising edge of the synchronized `ext_strobe` instead of the divider tick.
- R9: A rising edge of `cout` sets `rise_flag`, and a falling edge sets `fall_flag`. A 1 on `clr_rise` or `clr_fall` clears the matching flag. If an edge and a clear fall in the same cycle, the flag stays set.
- R10: `irq_rise` is `rise_flag`&`rise_ie` and `irq_fall` is `fall_flag`&`fall_ie`, both only when `dma_en`=0. When `dma_en`=1, both interrupt lines are 0 and `dma_req` is the OR of the enabled flags.
- R11: `pin_out` carries `cout` when `pin_unfilt`=0. When `pin_unfilt`=1 it carries the synchronized, inverted result, gated by `enable`.
- R12: After reset, `cout`, `pin_out`, both flags, both interrupt lines and `dma_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 forces outputs low |
| comp_raw | input | 1 | Raw asynchronous comparator result |
| invert | input | 1 | Invert the comparator result |
| mode | input | 3 | 0 continuous, 1 sampled, 2 sampled+filter, 3 windowed, 4 windowed+filter |
| ext_sel | input | 1 | Use the external strobe edges as sample ticks (modes 1, 2) |
| ext_strobe | input | 1 | External sample strobe, or the window in modes 3 and 4 |
| prescale | input | PRE_W | Divider value; tick period is prescale+1 cycles |
| filt_cnt | input | 3 | Number of agreeing samples; 0 disables the filter |
| pin_unfilt | input | 1 | Pin output carries the unfiltered result |
| rise_ie | input | 1 | Rising event enable |
| fall_ie | input | 1 | Falling event enable |
| dma_en | input | 1 | Route enabled events to the DMA request |
| clr_rise | input | 1 | Write-1 clear of the rising flag |
| clr_fall | input | 1 | Write-1 clear of the falling flag |
| cout | output | 1 | Conditioned comparator output |
| pin_out | output | 1 | Pin output, filtered or unfiltered |
| rise_flag | output | 1 | Sticky rising-edge flag |
| fall_flag | output | 1 | Sticky falling-edge flag |
| irq_rise | output | 1 | Rising interrupt |
| irq_fall | output | 1 | Falling interrupt |
| dma_req | output | 1 | DMA request |

## Verification
The rising-edge flag can be set by a new edge on `cout` in the same cycle that a write-1 clear arrives. The block must let the set win, so the event is not lost.

The bench provokes this collision on purpose. It changes `comp_raw`, counts the two synchronizer edges, and then raises `clr_rise` exactly in the cycle in which the edge detector sees the new `cout`. It then checks that `rise_flag` is still 1 after that edge. A second pass clears the flag without any coincident edge and checks that it drops, so both outcomes are tested.

// File: rtl/cmpc_pkg.sv
package cmpc_pkg;

  localparam int FCNT_W = 3;

  typedef enum logic [2:0] {
    MD_CONT  = 3'd0,
    MD_SAMP  = 3'd1,
    MD_SAMPF = 3'd2,
    MD_WIN   = 3'd3,
    MD_WINF  = 3'd4
  } cmpc_mode_e;

  // Number of agreeing samples the filter engine needs in a given mode.
  function automatic logic [FCNT_W-1:0] eff_need(cmpc_mode_e md, logic [FCNT_W-1:0] fc);
    if ((md == MD_SAMPF || md == MD_WINF) && fc != '0) return fc;
    return FCNT_W'(1);
  endfunction

  // True when one more disagreeing sample reaches the required run length.
  function automatic logic run_complete(logic [FCNT_W-1:0] run, logic [FCNT_W-1:0] need);
    return ({1'b0, run} + 1'b1) >= {1'b0, need};
  endfunction

  function automatic logic is_windowed(cmpc_mode_e md);
    return (md == MD_WIN) || (md == MD_WINF);
  endfunction

  function automatic logic uses_engine(cmpc_mode_e md);
    return (md == MD_SAMP) || (md == MD_SAMPF) || (md == MD_WINF);
  endfunction

endpackage

// File: rtl/cmpc_sync2.sv
module cmpc_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta, stable;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta   <= 1'b0;
        stable <= 1'b0;
      end else begin
        meta   <= d[i];
        stable <= meta;
      end
    end
    assign q[i] = stable;
  end
endmodule

// File: rtl/cmpc_prescale.sv
module cmpc_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);
  logic [PRE_W-1:0] cnt;

  assign tick = run && (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (!run)   cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cmpc_filter.sv
module cmpc_filter
  import cmpc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              tick,
  input  logic              din,
  input  logic [FCNT_W-1:0] need,
  output logic              q
);
  logic [FCNT_W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 1'b0;
      run <= '0;
    end else if (clr) begin
      q   <= 1'b0;
      run <= '0;
    end else if (tick) begin
      if (din == q) begin
        run <= '0;
      end else if (run_complete(run, need)) begin
        q   <= din;
        run <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmpout_conditioner.sv
module cmpout_conditioner
  import cmpc_pkg::*;
#(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             comp_raw,
  input  logic             invert,
  input  logic [2:0]       mode,
  input  logic             ext_sel,
  input  logic             ext_strobe,
  input  logic [PRE_W-1:0] prescale,
  input  logic [2:0]       filt_cnt,
  input  logic             pin_unfilt,
  input  logic             rise_ie,
  input  logic             fall_ie,
  input  logic             dma_en,
  input  logic             clr_rise,
  input  logic             clr_fall,
  output logic             cout,
  output logic             pin_out,
  output logic             rise_flag,
  output logic             fall_flag,
  output logic             irq_rise,
  output logic             irq_fall,
  output logic             dma_req
);
  cmpc_mode_e md;
  logic [1:0] sync_q;
  logic       cond, win_s, strobe_q, ext_edge, presc_tick, smp_tick;
  logic       held, wval, eng_in, eng_q, out_pre, unfilt, cout_q;
  logic       rise_ev, fall_ev;

  assign md = cmpc_mode_e'(mode);

  // Comparator result and strobe share one synchronizer so they stay aligned.
  cmpc_sync2 #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({ext_strobe, comp_raw}), .q(sync_q)
  );

  assign cond  = sync_q[0] ^ invert;
  assign win_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= win_s;
  end
  assign ext_edge = win_s & ~strobe_q;

  cmpc_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(enable), .div(prescale), .tick(presc_tick)
  );

  assign smp_tick = (ext_sel && (md == MD_SAMP || md == MD_SAMPF)) ? ext_edge : presc_tick;

  // Window gate: pass while open, hold last passed value while closed.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held <= 1'b0;
    else if (!enable) held <= 1'b0;
    else if (win_s)   held <= cond;
  end
  assign wval   = win_s ? cond : held;
  assign eng_in = is_windowed(md) ? wval : cond;

  cmpc_filter u_filt (
    .clk(clk), .rst_n(rst_n), .clr(!enable), .tick(smp_tick),
    .din(eng_in), .need(eff_need(md, filt_cnt)), .q(eng_q)
  );

  always_comb begin
    if (uses_engine(md))  out_pre = eng_q;
    else if (md == MD_WIN) out_pre = wval;
    else                  out_pre = cond;
  end

  assign cout    = enable & out_pre;
  assign unfilt  = enable & cond;
  assign pin_out = pin_unfilt ? unfilt : cout;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cout_q <= 1'b0;
    else        cout_q <= cout;
  end
  assign rise_ev = cout & ~cout_q;
  assign fall_ev = ~cout & cout_q;

  // Set has priority over a coincident write-1 clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_flag <= 1'b0;
      fall_flag <= 1'b0;
    end else begin
      rise_flag <= rise_ev | (rise_flag & ~clr_rise);
      fall_flag <= fall_ev | (fall_flag & ~clr_fall);
    end
  end

  assign irq_rise = rise_flag & rise_ie & ~dma_en;
  assign irq_fall = fall_flag & fall_ie & ~dma_en;
  assign dma_req  = dma_en & ((rise_flag & rise_ie) | (fall_flag & fall_ie));
endmodule

// File: rtl/cmpc_checker.sv
module cmpc_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic [2:0] mode,
  input logic       cout,
  input logic       pin_out,
  input logic       rise_flag,
  input logic       fall_flag,
  input logic       clr_rise,
  input logic       irq_rise,
  input logic       irq_fall,
  input logic       dma_en,
  input logic       dma_req,
  input logic       smp_tick,
  input logic       win_open
);
  assert_disabled_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!cout && !pin_out));

  assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mode == 3'd1 && $past(enable) && $past(mode) == 3'd1 && !$past(smp_tick))
      |-> $stable(cout));

  assert_window_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && mode == 3'd3 && $past(enable) && $past(mode) == 3'd3 &&
     !win_open && !$past(win_open)) |-> $stable(cout));

  assert_rise_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cout) |=> rise_flag);

  assert_fall_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cout) |=> fall_flag);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_rise && !(cout && !$past(cout))) |=> !rise_flag);

  assert_irq_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_en |-> (!irq_rise && !irq_fall));

  assert_dma_route_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_en && (rise_flag || fall_flag)));
endmodule

bind cmpout_conditioner cmpc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .cout(cout),
  .pin_out(pin_out), .rise_flag(rise_flag), .fall_flag(fall_flag),
  .clr_rise(clr_rise), .irq_rise(irq_rise), .irq_fall(irq_fall),
  .dma_en(dma_en), .dma_req(dma_req), .smp_tick(smp_tick), .win_open(win_s)
);

// File: tb/tb_cmpout_conditioner.sv
module tb_cmpout_conditioner;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 0, comp_raw = 0, invert = 0, ext_sel = 0, ext_strobe = 0;
  logic [2:0] mode = 0, filt_cnt = 0;
  logic [7:0] prescale = 0;
  logic pin_unfilt = 0, rise_ie = 0, fall_ie = 0, dma_en = 0, clr_rise = 0, clr_fall = 0;
  logic cout, pin_out, rise_flag, fall_flag, irq_rise, irq_fall, dma_req;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmpout_conditioner dut (.*);

  // {enable, invert, raw, pin_unfilt, expected cout, expected pin}
  localparam logic [5:0] VEC [6] = '{
    6'b1010_11, 6'b1000_00, 6'b1110_00, 6'b1101_11, 6'b0010_00, 6'b0101_00
  };

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_flags();
    clr_rise = 1; clr_fall = 1; edges(1); clr_rise = 0; clr_fall = 0;
  endtask

  initial begin
    int lat, changes;
    logic prev;
    @(negedge clk);
    chk(cout, 0, "R12 cout"); chk(rise_flag, 0, "R12 rise_flag");
    rst_n = 1; edges(1);
    chk(pin_out, 0, "R12 pin"); chk(fall_flag, 0, "R12 fall_flag");
    chk(dma_req | irq_rise | irq_fall, 0, "R12 events");

    // Continuous mode vectors: R1 R2 R3 R11
    for (int i = 0; i < 6; i++) begin
      {enable, invert, comp_raw, pin_unfilt} = VEC[i][5:2];
      edges(3);
      chk(cout, VEC[i][1], $sformatf("R1/R2/R3 vec%0d cout", i));
      chk(pin_out, VEC[i][0], $sformatf("R11/R3 vec%0d pin", i));
    end
    enable = 1; invert = 0; pin_unfilt = 0; comp_raw = 0; edges(4);
    // R1 exact delay
    comp_raw = 1; edges(1); chk(cout, 0, "R1 after one edge");
    edges(1); chk(cout, 1, "R1 after two edges");

    // R4 sampled, period 10
    comp_raw = 0; mode = 1; prescale = 9; edges(15);
    comp_raw = 1; lat = 0;
    for (int k = 1; k <= 20; k++) begin
      edges(1);
      if (cout && lat == 0) lat = k;
    end
    checks++;
    if (lat < 3 || lat > 12) begin errors++; $display("FAIL R4 latency actual %0d expected 3..12", lat); end
    changes = 0; prev = cout;
    for (int k = 0; k < 50; k++) begin
      comp_raw = ~comp_raw; edges(1);
      if (cout != prev) changes++;
      prev = cout;
    end
    checks++;
    if (changes > 6) begin errors++; $display("FAIL R4 changes actual %0d expected <=6", changes); end

    // R5 filter N=3, tick every cycle
    mode = 2; prescale = 0; filt_cnt = 3; comp_raw = 0; edges(10);
    chk(cout, 0, "R5 settle");
    comp_raw = 1; edges(2); comp_raw = 0;
    lat = 0;
    for (int k = 0; k < 8; k++) begin edges(1); if (cout) lat = 1; end
    chk(lat[0], 0, "R5 two-sample glitch rejected");
    comp_raw = 1; edges(4); chk(cout, 0, "R5 before third sample");
    edges(1); chk(cout, 1, "R5 third agreeing sample");
    // R5 N=0: no filtering
    filt_cnt = 0; comp_raw = 0; edges(2); chk(cout, 1, "R5 N0 before tick");
    edges(1); chk(cout, 0, "R5 N0 direct sample");

    // R8 external sample strobe
    enable = 0; edges(1); enable = 1;
    mode = 1; ext_sel = 1; prescale = 255; comp_raw = 1; edges(20);
    chk(cout, 0, "R8 no strobe edge");
    ext_strobe = 1; edges(2); chk(cout, 0, "R8 before strobe edge");
    edges(1); chk(cout, 1, "R8 strobe edge samples");
    ext_strobe = 0; ext_sel = 0; edges(3);

    // R6 windowed, R11 pin select
    mode = 3; ext_strobe = 1; comp_raw = 1; edges(4); chk(cout, 1, "R6 open follows 1");
    comp_raw = 0; edges(4); chk(cout, 0, "R6 open follows 0");
    comp_raw = 1; edges(4);
    ext_strobe = 0; edges(4);
    comp_raw = 0; edges(6); chk(cout, 1, "R6 closed holds");
    chk(pin_out, 1, "R11 pin filtered");
    pin_unfilt = 1; #1 chk(pin_out, 0, "R11 pin unfiltered");
    pin_unfilt = 0;
    ext_strobe = 1; edges(4); chk(cout, 0, "R6 reopen follows");

    // R7 windowed + filtered, N=2
    mode = 4; filt_cnt = 2; prescale = 0; edges(6); chk(cout, 0, "R7 settle");
    comp_raw = 1; edges(3); chk(cout, 0, "R7 one sample");
    edges(1); chk(cout, 1, "R7 two samples");
    ext_strobe = 0; edges(4); comp_raw = 0; edges(10); chk(cout, 1, "R7 closed holds");
    ext_strobe = 1; edges(8); chk(cout, 0, "R7 reopen filtered");

    // R9 R10 flags and routing
    mode = 0; comp_raw = 0; edges(4); clear_flags();
    chk(rise_flag | fall_flag, 0, "R9 cleared");
    rise_ie = 1; fall_ie = 1;
    comp_raw = 1; edges(4);
    chk(rise_flag, 1, "R9 rise set"); chk(fall_flag, 0, "R9 no fall");
    chk(irq_rise, 1, "R10 irq_rise"); chk(dma_req, 0, "R10 no dma");
    dma_en = 1; #1;
    chk(irq_rise, 0, "R10 irq masked by dma"); chk(dma_req, 1, "R10 dma_req");
    @(negedge clk);
    clr_rise = 1; edges(1); clr_rise = 0;
    chk(rise_flag, 0, "R9 write-1 clear"); chk(dma_req, 0, "R10 dma drops");
    dma_en = 0; comp_raw = 0; edges(4);
    chk(fall_flag, 1, "R9 fall set"); chk(irq_fall, 1, "R10 irq_fall");
    fall_ie = 0; #1 chk(irq_fall, 0, "R10 fall enable off");
    @(negedge clk);
    // R9 coincident set and clear: set wins
    comp_raw = 1; repeat (2) @(posedge clk); @(negedge clk);
    clr_rise = 1; @(posedge clk); @(negedge clk); clr_rise = 0;
    chk(rise_flag, 1, "R9 set wins over clear");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule